// File: doc/BRIEF.md
# Tiled Plot Address Generator

This block turns a pixel coordinate into the byte address of the tile that holds it in a tiled bitmap framebuffer. Tiles are 8x8 pixels, and their size in bytes follows the colour depth. In the normal layouts the tiles are stored column by column, so a step of one tile column skips a whole column of tiles, and the number of tiles in a column depends on the selected screen height. A separate 256-line layout stores four quadrants of 16x16 tiles. It is also used for drawing into sprite memory whenever the sprite layout flag is set.

The screen base comes from an 8-bit register in 1 KiB units. If the screen would run past the end of RAM, the base is pulled down so that the whole screen fits. A request (x, y, valid) is accepted on any cycle. The address appears one clock later together with a valid flag. The configuration inputs are sampled in the same cycle as the request.

Top module: `plot_addr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `addr_valid` and `addr` are both zero.
- R2: `addr_valid` is high in the cycle after `req_valid` is high, and low in the cycle after `req_valid` is low.
- R3: Tile size T follows `depth_sel`: 0 gives 16 bytes, 1 gives 32 bytes, and 2 or 3 give 64 bytes.
- R4: With `height_sel` 0, 1 or 2 (128, 160 or 192 lines, so H = 16, 20 or 24 tiles per column) and `sprite_mode` low, the offset is (row + col*H)*T, where row = y>>3 and col = x>>3.
- R5: With `height_sel` = 3 (256 lines), the offset is (row[4]*512 + col[4]*256 + row[3:0]*16 + col[3:0])*T.
- R6: When `sprite_mode` is 1, the R5 layout is used whatever the value of `height_sel`.
- R7: The unclamped screen base is `scr_base`*1024.
- R8: The screen size S is (H*32)*T for `height_sel` 0 to 2, and 32768 bytes for `height_sel` 3. If base + S exceeds 2^ADDR_W, the base becomes 2^ADDR_W - S.
- R9: The screen size used for clamping does not depend on `sprite_mode`, and with `height_sel` 3 it does not depend on `depth_sel`.
- R10: The address is base + offset modulo 2^ADDR_W. It keeps its value through cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| height_sel | input | 2 | Screen height: 0=128, 1=160, 2=192, 3=256 lines |
| depth_sel | input | 2 | Colour depth selecting the tile size |
| sprite_mode | input | 1 | Forces the 256-line quadrant layout |
| scr_base | input | BASE_W | Screen base in 1 KiB units |
| req_valid | input | 1 | Pixel request strobe |
| req_x | input | COORD_W | Pixel column |
| req_y | input | COORD_W | Pixel row |
| addr_valid | output | 1 | Address valid, one cycle after the request |
| addr | output | ADDR_W | Tile byte address |

## Verification
Several properties are checked by assertions on every cycle: the one-cycle valid timing, the held address when no request arrives, and the fact that the clamped base never moves up and always leaves room for the whole screen. The exact tile arithmetic can only be shown by the bench's sweeps. This covers the column stride per height, the quadrant bit order, the sprite override, and the clamp values at the top of RAM. The sweeps cover every height, depth and sprite setting, with bases that both clamp and do not clamp.

// File: rtl/plot_addr_pkg.sv
package plot_addr_pkg;

    typedef enum logic [1:0] {
        HGT_128 = 2'd0,
        HGT_160 = 2'd1,
        HGT_192 = 2'd2,
        HGT_256 = 2'd3
    } height_e;

    typedef enum logic [1:0] {
        DEPTH_LO  = 2'd0,
        DEPTH_MID = 2'd1,
        DEPTH_HI  = 2'd2,
        DEPTH_HI2 = 2'd3
    } depth_e;

    localparam int TILE_PIX_BITS = 3;
    localparam int COLS_PER_SCREEN = 32;
    localparam int TALL_SCREEN_BYTES = 32768;

    // log2 of the tile size in bytes
    function automatic logic [2:0] tile_shift(depth_e d);
        case (d)
            DEPTH_LO:  return 3'd4;
            DEPTH_MID: return 3'd5;
            default:   return 3'd6;
        endcase
    endfunction

    // tiles stacked in one column of the screen
    function automatic logic [5:0] tile_rows(height_e h);
        case (h)
            HGT_128: return 6'd16;
            HGT_160: return 6'd20;
            HGT_192: return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [31:0] screen_bytes(height_e h, depth_e d);
        if (h == HGT_256)
            return 32'(TALL_SCREEN_BYTES);
        return (32'(tile_rows(h)) * 32'(COLS_PER_SCREEN)) << tile_shift(d);
    endfunction

endpackage

// File: rtl/plot_base_clamp.sv
module plot_base_clamp
    import plot_addr_pkg::*;
#(
    parameter int BASE_W     = 8,
    parameter int ADDR_W     = 18,
    parameter int BASE_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] base_reg,
    input  height_e           height,
    input  depth_e            depth,
    output logic [ADDR_W-1:0] eff_base
);
    localparam int SUM_W = ADDR_W + 2;

    logic [SUM_W-1:0] raw_base, scr_size, ram_end, eff_wide;

    always_comb begin
        raw_base = SUM_W'(base_reg) << BASE_SHIFT;
        scr_size = SUM_W'(screen_bytes(height, depth));
        ram_end  = SUM_W'(1) << ADDR_W;
        if (raw_base + scr_size > ram_end)
            eff_wide = ram_end - scr_size;
        else
            eff_wide = raw_base;
        eff_base = eff_wide[ADDR_W-1:0];
    end

    // R8
    screen_fits_chk: assert property (@(posedge clk) disable iff (rst)
        SUM_W'(eff_base) + scr_size <= ram_end);

    // R8
    base_not_raised_chk: assert property (@(posedge clk) disable iff (rst)
        SUM_W'(eff_base) <= raw_base);

endmodule

// File: rtl/plot_tile_offset.sv
module plot_tile_offset
    import plot_addr_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int OFF_W   = 18
) (
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  height_e            height,
    input  depth_e             depth,
    input  logic               quad_layout,
    output logic [OFF_W-1:0]   offset
);
    localparam int CELL_W = COORD_W - TILE_PIX_BITS;
    localparam int HALF   = CELL_W - 1;

    logic [CELL_W-1:0] row, col;
    logic [OFF_W-1:0]  tile_idx;

    assign row = py[COORD_W-1:TILE_PIX_BITS];
    assign col = px[COORD_W-1:TILE_PIX_BITS];

    always_comb begin
        if (quad_layout)
            tile_idx = OFF_W'({row[HALF], col[HALF], row[HALF-1:0], col[HALF-1:0]});
        else
            tile_idx = OFF_W'(col) * OFF_W'(tile_rows(height)) + OFF_W'(row);
        offset = tile_idx << tile_shift(depth);
    end

endmodule

// File: rtl/plot_addr_gen.sv
module plot_addr_gen
    import plot_addr_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int BASE_W  = 8,
    parameter int ADDR_W  = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         height_sel,
    input  logic [1:0]         depth_sel,
    input  logic               sprite_mode,
    input  logic [BASE_W-1:0]  scr_base,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    output logic               addr_valid,
    output logic [ADDR_W-1:0]  addr
);
    height_e           hgt;
    depth_e            dep;
    logic              quad;
    logic [ADDR_W-1:0] base_q, tile_off, next_addr;

    assign hgt  = height_e'(height_sel);
    assign dep  = depth_e'(depth_sel);
    assign quad = sprite_mode | (hgt == HGT_256);

    plot_base_clamp #(.BASE_W(BASE_W), .ADDR_W(ADDR_W), .BASE_SHIFT(10)) u_clamp (
        .clk      (clk),
        .rst      (rst),
        .base_reg (scr_base),
        .height   (hgt),
        .depth    (dep),
        .eff_base (base_q)
    );

    plot_tile_offset #(.COORD_W(COORD_W), .OFF_W(ADDR_W)) u_offset (
        .px          (req_x),
        .py          (req_y),
        .height      (hgt),
        .depth       (dep),
        .quad_layout (quad),
        .offset      (tile_off)
    );

    assign next_addr = base_q + tile_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            addr       <= '0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid)
                addr <= next_addr;
        end
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !addr_valid);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(addr));

endmodule

// File: tb/test_plot_addr_gen.sv
module test_plot_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 18;
    localparam int RAM_SZ = 1 << ADDR_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       height_sel = '0;
    logic [1:0]       depth_sel = '0;
    logic             sprite_mode = 1'b0;
    logic [7:0]       scr_base = '0;
    logic             req_valid = 1'b0;
    logic [7:0]       req_x = '0;
    logic [7:0]       req_y = '0;
    logic             addr_valid;
    logic [ADDR_W-1:0] addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plot_addr_gen #(.COORD_W(8), .BASE_W(8), .ADDR_W(ADDR_W)) i_plot_addr_gen (
        .clk(clk), .rst(rst), .height_sel(height_sel), .depth_sel(depth_sel),
        .sprite_mode(sprite_mode), .scr_base(scr_base), .req_valid(req_valid),
        .req_x(req_x), .req_y(req_y), .addr_valid(addr_valid), .addr(addr)
    );

    function automatic int tsize(int m);
        return (m == 0) ? 16 : (m == 1) ? 32 : 64;
    endfunction

    function automatic int ssize(int h, int m);
        int rows = (h == 0) ? 16 : (h == 1) ? 20 : (h == 2) ? 24 : 32;
        return (h == 3) ? 32768 : rows * 32 * tsize(m);
    endfunction

    function automatic int model(int h, int m, int spr, int b, int x, int y);
        int t = tsize(m);
        int rows = (h == 0) ? 16 : (h == 1) ? 20 : (h == 2) ? 24 : 32;
        int base = b * 1024;
        int r = y / 8;
        int c = x / 8;
        int off;
        if (base + ssize(h, m) > RAM_SZ) base = RAM_SZ - ssize(h, m);
        if (h == 3 || spr != 0)
            off = ((r / 16) * 512 + (c / 16) * 256 + (r % 16) * 16 + (c % 16)) * t;
        else
            off = (r + c * rows) * t;
        return (base + off) % RAM_SZ;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic request(int h, int m, int spr, int b, int x, int y);
        height_sel = 2'(h); depth_sel = 2'(m); sprite_mode = 1'(spr);
        scr_base = 8'(b); req_x = 8'(x); req_y = 8'(y); req_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1 valid", int'(addr_valid), 0);
        check("R1 addr", int'(addr), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after release", int'(addr_valid), 0);

        // R7: base of 5 KiB, pixel at origin
        request(0, 0, 0, 5, 0, 0);
        check("R7 base", int'(addr), 5120);
        check("R2 valid", int'(addr_valid), 1);

        // R3: next tile row down is one tile further
        for (int m = 0; m < 4; m++) begin
            request(1, m, 0, 0, 0, 8);
            check("R3 tile size", int'(addr), tsize(m));
        end

        // R9: tall screen clamps with 32 KiB regardless of depth or sprite flag
        request(3, 3, 0, 255, 0, 0);
        check("R9 tall depth3", int'(addr), RAM_SZ - 32768);
        request(3, 0, 1, 255, 0, 0);
        check("R9 tall sprite", int'(addr), RAM_SZ - 32768);
        request(0, 2, 1, 255, 0, 0);
        check("R9 sprite size", int'(addr), RAM_SZ - 16*32*64);

        // R10 / R2: no request keeps address, drops valid
        request(2, 1, 0, 3, 100, 60);
        begin
            int held = model(2, 1, 0, 3, 100, 60);
            check("R10 addr", int'(addr), held);
            req_valid = 1'b0; req_x = 8'd7; req_y = 8'd200; scr_base = 8'd90;
            @(negedge clk);
            check("R2 no valid", int'(addr_valid), 0);
            check("R10 hold", int'(addr), held);
        end

        // sweep of every configuration
        for (int h = 0; h < 4; h++)
            for (int m = 0; m < 4; m++)
                for (int spr = 0; spr < 2; spr++)
                    for (int bi = 0; bi < 4; bi++) begin
                        int b = (bi == 0) ? 0 : (bi == 1) ? 64 : (bi == 2) ? 200 : 255;
                        for (int xi = 0; xi < 9; xi++)
                            for (int yi = 0; yi < 9; yi++) begin
                                int x = (xi == 8) ? 255 : xi * 31;
                                int y = (yi == 8) ? 255 : yi * 29;
                                string tag;
                                if (b * 1024 + ssize(h, m) > RAM_SZ) tag = "R8 clamp";
                                else if (spr != 0 && h != 3) tag = "R6 sprite";
                                else if (h == 3) tag = "R5 quad";
                                else tag = "R4 column";
                                request(h, m, spr, b, x, y);
                                check(tag, int'(addr), model(h, m, spr, b, x, y));
                            end
                    end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule